// File: doc/BRIEF.md
# Lossless Pixel Tile Decompressor

This block rebuilds an 8x8 tile of 32-bit pixels (256 bytes) from a compressed payload that arrives as 32-byte beats over a valid/ready stream. A two-bit format code comes with the first beat of each tile. The block expands the payload in one of four ways: a constant value per 4x2 region, a constant value per 2x2 region, per-channel packed differences, or an uncompressed copy. It then streams the 64 pixels out in row-major order, one per accepted cycle. The output must match the original tile bit for bit.

A read client such as a texture or cache fill path places it behind memory. The client feeds it the compressed beats of one tile and consumes the pixel stream. The block works on one tile at a time. It takes no beat of the next tile until the last pixel of the current tile has been taken.

The controller is a four-state machine. IDLE waits for the first beat and latches the format. LOAD collects the remaining beats. DECODE rebuilds a difference-coded tile into a pixel store, one pixel per cycle, for 64 cycles. EMIT streams the pixels. Its transitions are as follows:
- `first_beat_more` goes from IDLE to LOAD.
- `first_beat_only` goes from IDLE to DECODE for the difference format, or to EMIT for any other format.
- `load_done` goes from LOAD to DECODE or EMIT.
- `decode_done` goes from DECODE to EMIT after step 63.
- `tile_sent` goes from EMIT to IDLE when pixel 63 is taken.

Top module: `tile_decomp`

## Requirements
- R1: After reset `in_ready` is 1 and `pix_valid` is 0. A beat is taken on a cycle where `in_valid` and `in_ready` are both high. The format code is read only from the first beat of a tile, and `in_mode` on later beats has no effect.
- R2: Format code 01 takes one beat. The 32-bit word at bits [32k+31:32k] is copied into all eight pixels of region k = (row/2)*2 + col/4.
- R3: Format code 10 takes two beats. Beat j fills payload bits [256j+255:256j]. The word at bits [32k+31:32k] is copied into all four pixels of region k = (row/2)*4 + col/2.
- R4: Format code 00 takes eight beats, with beat j filling payload bits [256j+255:256j]. Pixel i = row*8+col is output unchanged from bits [32i+31:32i].
- R5: In format code 11, the first beat carries a header. Bits [4c+3:4c] hold the width of channel c, for c = 0..3. Bits [18:16] hold the beat count minus one, and the block takes exactly that many beats. Bits [63:32] hold pixel 0, and packed differences start at bit 64.
- R6: Format code 11 visits pixels in serpentine order: even rows run left to right and odd rows right to left. For each step after the first, channels 0..3 take their difference LSB-first from consecutive payload bits. Channel c is pixel bits [8c+7:8c]. Each difference is sign-extended from its width and added modulo 256 to the same channel of the previous pixel in the scan.
- R7: A width field of 0 reads no bits and leaves the channel unchanged. A width field above 8 is decoded as 8.
- R8: Pixels leave in row-major order, one per cycle while `pix_ready` is high. `pix_last` is high exactly on pixel 63. While `pix_ready` is low, `pix_data` and `pix_last` hold.
- R9: `in_ready` is low from the final beat of a tile until pixel 63 of that tile is taken, so input acceptance and pixel output never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed beat present |
| in_ready | output | 1 | Block can take a beat |
| in_mode | input | 2 | Format code, read on the first beat of a tile |
| in_data | input | 256 | Compressed beat |
| pix_valid | output | 1 | Output pixel present |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_data | output | 32 | Reconstructed pixel |
| pix_last | output | 1 | Marks pixel 63 of the tile |

## Verification
A wrong bit offset in the difference decoder does not stay local. Every pixel after the faulty step in the serpentine scan goes wrong, and the first bad pixel reaches the port within one tile's output. A wrong beat count or format latch shows up immediately as wrong data from the first affected pixel. It can also leave the stream out of step, and then the next tile decodes as garbage. Faults in the state machine show up as `in_ready` and `pix_valid` high together, as `pix_last` on the wrong pixel, or as output that changes during a stall, all on the cycle they occur.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
    localparam int PIX_W      = 32;
    localparam int CH_W       = 8;
    localparam int NCH        = PIX_W / CH_W;
    localparam int WFLD_W     = 4;
    localparam int HDR_W      = 64;
    localparam int ANCHOR_LSB = 32;
    localparam int CNT_LSB    = 16;

    typedef enum logic [1:0] {
        MODE_RAW   = 2'b00,
        MODE_C42   = 2'b01,
        MODE_C22   = 2'b10,
        MODE_DELTA = 2'b11
    } tile_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DECODE,
        ST_EMIT
    } dec_state_e;
endpackage

// File: rtl/tdc_delta_step.sv
`timescale 1ns/1ps
module tdc_delta_step
    import tdc_pkg::*;
#(
    parameter int UW = $clog2(PIX_W) + 1
)
(
    input  logic [PIX_W-1:0]        window,
    input  logic [NCH*WFLD_W-1:0]   wfield,
    input  logic [PIX_W-1:0]        prev_pix,
    output logic [PIX_W-1:0]        next_pix,
    output logic [UW-1:0]           used_bits
);
    localparam int CIW = $clog2(CH_W);

    logic [UW-1:0] wid   [NCH];
    logic [UW-1:0] shift [NCH];

    // width clamp: fields above one channel width decode as a full channel
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            if (wfield[c*WFLD_W +: WFLD_W] > WFLD_W'(CH_W))
                wid[c] = UW'(CH_W);
            else
                wid[c] = UW'(wfield[c*WFLD_W +: WFLD_W]);
        end
    end

    // running bit position of each channel inside the window
    always_comb begin
        shift[0] = '0;
        for (int c = 1; c < NCH; c++)
            shift[c] = shift[c-1] + wid[c-1];
        used_bits = shift[NCH-1] + wid[NCH-1];
    end

    always_comb begin
        AST_USED_FIT: assert (used_bits <= UW'(PIX_W)); // R7
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CH_W-1:0] mask;
        logic [CH_W-1:0] raw;
        logic [CH_W-1:0] dlt;
        logic            neg;
        always_comb begin
            mask = CH_W'((16'd1 << wid[c]) - 16'd1);
            raw  = CH_W'(window >> shift[c]) & mask;
            neg  = (wid[c] != '0) && raw[CIW'(wid[c] - 1'b1)];
            dlt  = neg ? (raw | ~mask) : raw;
        end
        assign next_pix[c*CH_W +: CH_W] = prev_pix[c*CH_W +: CH_W] + dlt;
    end
endmodule

// File: rtl/tdc_pix_select.sv
`timescale 1ns/1ps
module tdc_pix_select
    import tdc_pkg::*;
#(
    parameter int SIDE      = 8,
    parameter int TILE_BITS = SIDE * SIDE * PIX_W,
    parameter int IDX_W     = $clog2(SIDE * SIDE)
)
(
    input  tile_mode_e              mode,
    input  logic [TILE_BITS-1:0]    payload,
    input  logic [PIX_W-1:0]        dec_pix,
    input  logic [IDX_W-1:0]        idx,
    output logic [PIX_W-1:0]        pix
);
    localparam int SW = $clog2(SIDE);

    logic [SW-1:0]    row;
    logic [SW-1:0]    col;
    logic [IDX_W-1:0] r42;
    logic [IDX_W-1:0] r22;

    assign row = idx[IDX_W-1:SW];
    assign col = idx[SW-1:0];

    always_comb begin
        r42 = IDX_W'((int'(row) / 2) * (SIDE / 4) + int'(col) / 4);
        r22 = IDX_W'((int'(row) / 2) * (SIDE / 2) + int'(col) / 2);
    end

    always_comb begin
        unique case (mode)
            MODE_C42:   pix = payload[r42 * PIX_W +: PIX_W];
            MODE_C22:   pix = payload[r22 * PIX_W +: PIX_W];
            MODE_RAW:   pix = payload[idx * PIX_W +: PIX_W];
            MODE_DELTA: pix = dec_pix;
        endcase
    end
endmodule

// File: rtl/tile_decomp.sv
`timescale 1ns/1ps
module tile_decomp
    import tdc_pkg::*;
#(
    parameter int BEAT_W = 256,
    parameter int SIDE   = 8
)
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_mode,
    input  logic [BEAT_W-1:0]   in_data,
    output logic                pix_valid,
    input  logic                pix_ready,
    output logic [PIX_W-1:0]    pix_data,
    output logic                pix_last
);
    localparam int NPIX      = SIDE * SIDE;
    localparam int IDX_W     = $clog2(NPIX);
    localparam int SW        = $clog2(SIDE);
    localparam int TILE_BITS = NPIX * PIX_W;
    localparam int NBEATS    = TILE_BITS / BEAT_W;
    localparam int BI_W      = $clog2(NBEATS);
    localparam int OFF_W     = $clog2(TILE_BITS + PIX_W + 1);
    localparam int UW        = $clog2(PIX_W) + 1;
    localparam int C42_BEATS = (NPIX / 8) * PIX_W / BEAT_W;
    localparam int C22_BEATS = (NPIX / 4) * PIX_W / BEAT_W;

    dec_state_e state_q, state_d;
    tile_mode_e mode_q, mode_in;

    logic [BI_W-1:0]        beat_q;
    logic [BI_W-1:0]        beat_sel;
    logic [BI_W:0]          tot_q;
    logic [BI_W:0]          tot_first;
    logic [TILE_BITS-1:0]   pay_q;
    logic [PIX_W-1:0]       dstore [NPIX];
    logic [PIX_W-1:0]       prev_q;
    logic [PIX_W-1:0]       last_out_q;
    logic [OFF_W-1:0]       off_q;
    logic [IDX_W-1:0]       step_q;
    logic [IDX_W-1:0]       cnt_q;
    logic                   in_fire;
    logic                   pix_fire;
    logic                   load_done;

    logic [TILE_BITS+PIX_W-1:0] ext;
    logic [PIX_W-1:0]           window;
    logic [PIX_W-1:0]           anchor;
    logic [PIX_W-1:0]           delta_pix;
    logic [PIX_W-1:0]           dec_val;
    logic [UW-1:0]              used_bits;
    logic [IDX_W-1:0]           serp_idx;
    logic [SW-1:0]              s_row;
    logic [SW-1:0]              s_col;

    assign mode_in  = tile_mode_e'(in_mode);
    assign in_fire  = in_valid && in_ready;
    assign pix_fire = pix_valid && pix_ready;
    assign beat_sel = (state_q == ST_IDLE) ? '0 : beat_q;

    // beats owed by the tile, decided on its first beat
    always_comb begin
        unique case (mode_in)
            MODE_C42:   tot_first = (BI_W+1)'(C42_BEATS);
            MODE_C22:   tot_first = (BI_W+1)'(C22_BEATS);
            MODE_RAW:   tot_first = (BI_W+1)'(NBEATS);
            MODE_DELTA: tot_first = (BI_W+1)'(in_data[CNT_LSB +: BI_W]) + 1'b1;
        endcase
    end

    assign load_done = in_fire &&
                       (((state_q == ST_IDLE) && (tot_first == (BI_W+1)'(1))) ||
                        ((state_q == ST_LOAD) && ({1'b0, beat_q} == tot_q - 1'b1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_fire) begin
                    if (load_done)
                        state_d = (mode_in == MODE_DELTA) ? ST_DECODE : ST_EMIT;
                    else
                        state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (load_done)
                    state_d = (mode_q == MODE_DELTA) ? ST_DECODE : ST_EMIT;
            end
            ST_DECODE: begin
                if (step_q == IDX_W'(NPIX - 1)) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (pix_fire && pix_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE) || (state_q == ST_LOAD);
        pix_valid = (state_q == ST_EMIT);
        pix_last  = (state_q == ST_EMIT) && (cnt_q == IDX_W'(NPIX - 1));
    end

    // payload capture
    always_ff @(posedge clk) begin
        if (in_fire) pay_q[beat_sel * BEAT_W +: BEAT_W] <= in_data;
    end

    // serpentine scan position to row-major index
    assign s_row    = step_q[IDX_W-1:SW];
    assign s_col    = s_row[0] ? ~step_q[SW-1:0] : step_q[SW-1:0];
    assign serp_idx = {s_row, s_col};

    assign ext    = {{PIX_W{1'b0}}, pay_q};
    assign window = ext[off_q +: PIX_W];
    assign anchor = pay_q[ANCHOR_LSB +: PIX_W];

    tdc_delta_step #(
        .UW         (UW)
    ) u_delta (
        .window     (window),
        .wfield     (pay_q[NCH*WFLD_W-1:0]),
        .prev_pix   (prev_q),
        .next_pix   (delta_pix),
        .used_bits  (used_bits)
    );

    assign dec_val = (step_q == '0) ? anchor : delta_pix;

    always_ff @(posedge clk) begin
        if (state_q == ST_DECODE) dstore[serp_idx] <= dec_val;
    end

    // control counters and decode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_RAW;
            beat_q     <= '0;
            tot_q      <= '0;
            off_q      <= OFF_W'(HDR_W);
            step_q     <= '0;
            cnt_q      <= '0;
            prev_q     <= '0;
            last_out_q <= '0;
        end else begin
            if ((state_q == ST_IDLE) && in_fire) begin
                mode_q <= mode_in;
                tot_q  <= tot_first;
                beat_q <= BI_W'(1);
            end else if ((state_q == ST_LOAD) && in_fire) begin
                beat_q <= beat_q + 1'b1;
            end

            if (state_q == ST_DECODE) begin
                step_q <= step_q + 1'b1;
                prev_q <= dec_val;
                if (step_q != '0) off_q <= off_q + OFF_W'(used_bits);
            end else begin
                step_q <= '0;
                off_q  <= OFF_W'(HDR_W);
            end

            if (pix_fire) begin
                cnt_q      <= cnt_q + 1'b1;
                last_out_q <= pix_data;
            end
        end
    end

    tdc_pix_select #(
        .SIDE       (SIDE),
        .TILE_BITS  (TILE_BITS),
        .IDX_W      (IDX_W)
    ) u_sel (
        .mode       (mode_q),
        .payload    (pay_q),
        .dec_pix    (dstore[cnt_q]),
        .idx        (cnt_q),
        .pix        (pix_data)
    );

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_last)); // R8
    AST_LAST_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && pix_last |=> !pix_valid && in_ready); // R9
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && pix_valid)); // R9
    AST_C42_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && (mode_q == MODE_C42) && (cnt_q[1:0] != 2'b00) |-> pix_data == last_out_q); // R2
    AST_C22_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && (mode_q == MODE_C22) && cnt_q[0] |-> pix_data == last_out_q); // R3
    AST_OFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |-> off_q <= OFF_W'(TILE_BITS)); // R5
endmodule

// File: tb/tile_decomp_tb.sv
`timescale 1ns/1ps
module tile_decomp_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_mode = 2'b00;
    logic [255:0] in_data = '0;
    logic         pix_valid;
    logic         pix_ready;
    logic [31:0]  pix_data;
    logic         pix_last;

    int checks = 0;
    int errors = 0;
    int out_idx = 0;
    bit stall_en = 1'b0;

    logic [31:0]   exp_q [$];
    string         tag_q [$];
    logic [31:0]   tile [64];
    logic [2047:0] pay;
    int            nbeats;

    always #5 clk = ~clk;

    tile_decomp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .pix_data  (pix_data),
        .pix_last  (pix_last)
    );

    function automatic int serp(input int s);
        int r = s / 8;
        int c = s % 8;
        return r * 8 + ((r % 2) ? 7 - c : c);
    endfunction

    function automatic int need_w(input int d);
        if (d == 0) return 0;
        for (int w = 1; w <= 8; w++)
            if (d >= -(1 << (w - 1)) && d <= (1 << (w - 1)) - 1) return w;
        return 8;
    endfunction

    task automatic build_c42();
        logic [31:0] v [8];
        pay = '0;
        for (int k = 0; k < 8; k++) begin v[k] = $urandom; pay[k*32 +: 32] = v[k]; end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) tile[r*8+c] = v[(r/2)*2 + c/4];
        nbeats = 1;
    endtask

    task automatic build_c22();
        logic [31:0] v [16];
        pay = '0;
        for (int k = 0; k < 16; k++) begin v[k] = $urandom; pay[k*32 +: 32] = v[k]; end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) tile[r*8+c] = v[(r/2)*4 + c/2];
        nbeats = 2;
    endtask

    task automatic build_raw();
        for (int i = 0; i < 64; i++) begin tile[i] = $urandom; pay[i*32 +: 32] = tile[i]; end
        nbeats = 8;
    endtask

    task automatic build_delta(input int sp0, input int sp1, input int sp2, input int sp3,
                               input bit wide_hdr);
        int sp [4];
        int dl [64][4];
        int wm [4];
        int cur [4];
        int pos;
        logic [31:0] anc;
        logic [31:0] pv;
        sp = '{sp0, sp1, sp2, sp3};
        anc = $urandom;
        tile[0] = anc;
        for (int c = 0; c < 4; c++) begin cur[c] = int'(anc[c*8 +: 8]); wm[c] = 0; end
        for (int s = 1; s < 64; s++) begin
            pv = '0;
            for (int c = 0; c < 4; c++) begin
                int d;
                d = (sp[c] == 0) ? 0 : int'($urandom_range(2 * sp[c] - 1)) - sp[c];
                dl[s][c] = d;
                cur[c] = (cur[c] + d) & 255;
                if (need_w(d) > wm[c]) wm[c] = need_w(d);
                pv[c*8 +: 8] = 8'(cur[c]);
            end
            tile[serp(s)] = pv;
        end
        pay = '0;
        for (int c = 0; c < 4; c++) pay[c*4 +: 4] = 4'(wm[c]);
        if (wide_hdr && wm[0] == 8) pay[3:0] = 4'hF;  // R7: field above 8
        pay[63:32] = anc;
        pos = 64;
        for (int s = 1; s < 64; s++)
            for (int c = 0; c < 4; c++)
                for (int b = 0; b < wm[c]; b++) begin
                    pay[pos] = dl[s][c][b];
                    pos++;
                end
        nbeats = (pos + 255) / 256;
        pay[18:16] = 3'(nbeats - 1);
    endtask

    task automatic send_tile(input logic [1:0] m, input string tag);
        for (int i = 0; i < 64; i++) begin exp_q.push_back(tile[i]); tag_q.push_back(tag); end
        for (int b = 0; b < nbeats; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_mode  = (b == 0) ? m : ~m;   // R1: later beats carry a wrong code
            in_data  = pay[b*256 +: 256];
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // scoreboard monitor: owns pix_ready, samples 1 ns after the falling edge
    always begin
        logic [31:0] e;
        string t;
        @(negedge clk);
        pix_ready = stall_en ? ($urandom_range(2) != 0) : 1'b1;
        #1;
        if (rst_n && pix_valid) begin
            checks++;
            if (in_ready) begin
                errors++;
                $display("FAIL R9 in_ready=%0b expected 0 while pixels are out", in_ready);
            end
            if (pix_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8 extra pixel %h expected none", pix_data);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (pix_data !== e) begin
                        errors++;
                        $display("FAIL %s pixel %0d got %h expected %h", t, out_idx, pix_data, e);
                    end
                    checks++;
                    if (pix_last !== (out_idx == 63)) begin
                        errors++;
                        $display("FAIL R8 last flag at pixel %0d got %0b expected %0b",
                                 out_idx, pix_last, out_idx == 63);
                    end
                    out_idx = (out_idx + 1) % 64;
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (in_ready !== 1'b1 || pix_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset in_ready=%0b pix_valid=%0b expected 1 0", in_ready, pix_valid);
        end

        build_c42();              send_tile(2'b01, "R2");
        build_c22();              send_tile(2'b10, "R3");
        build_raw();              send_tile(2'b00, "R4");
        build_delta(1, 2, 4, 8, 1'b0);       send_tile(2'b11, "R6");
        build_delta(0, 0, 0, 0, 1'b0);       send_tile(2'b11, "R5");
        build_delta(128, 128, 128, 0, 1'b1); send_tile(2'b11, "R7");
        build_delta(8, 0, 3, 128, 1'b0);     send_tile(2'b11, "R6");
        stall_en = 1'b1;
        build_raw();              send_tile(2'b00, "R4");
        build_c42();              send_tile(2'b01, "R2");
        build_delta(16, 1, 0, 64, 1'b0);     send_tile(2'b11, "R6");
        build_c22();              send_tile(2'b10, "R3");

        while (exp_q.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired with %0d pixels outstanding expected 0", exp_q.size());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule